// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block sits between a pulse-width controller and the gate drivers of a full bridge. Each of the two legs, A and B, has a high-side and a low-side switch, so the block takes four command inputs and drives four gate-enable outputs. A command is acted on only after it has held a new level for a minimum number of clocks. Within a leg, a low-side command wins over a high-side command. Both switches of a leg are never on together. A switch turns on only after a programmable dead time in which both switches of its leg have been off.

An active-low disable input overrides all four commands and keeps both high-side gates off. When disable is entered, the block turns all gates off for one clock. It then turns both low-side gates on together for a programmable refresh interval, which recharges the bootstrap capacitors, and holds them off after that. Two undervoltage flags arrive as digital inputs. The main-supply flag blanks all four gates. The high-side-supply flag blanks only the two high-side gates. The dead time and the refresh width are counted in clock cycles. Both are captured from the configuration inputs while reset is held.

Top module: `hbridge_gate_ctl`

## Requirements
- R1: Neither leg ever has its high and low gate on in the same cycle. Every other combination of the four gates, including high on one leg with low on the other, is reachable from the commands.
- R2: Within a leg, when the accepted low command is 1, the low gate is driven and the high gate stays off, whatever the high command is.
- R3: When the accepted command of a leg changes, the gate that is on turns off on the next clock. Bit order is {gate_ah, gate_al, gate_bh, gate_bl}. The opposite gate of that leg turns on only after exactly max(D,1) consecutive cycles in which both gates of the leg are off, where D is the captured dead time.
- R4: Consider a clock edge that samples dis_n low. From the cycle after that edge, both high-side gates are off for as long as dis_n stays low.
- R5: The first edge that samples dis_n low turns all gates off. Both low gates then go on together for exactly W cycles, where W is the captured refresh width, and stay off for the rest of the disable. When W is 0, no pulse is produced.
- R6: When uv_main is sampled high, all four gates are off from the next cycle, whatever the other inputs are.
- R7: When uv_hs is sampled high, both high-side gates are off from the next cycle, while the low-side gates still follow their commands.
- R8: A command level is accepted only after it has been sampled unchanged on FILT_LEN consecutive edges. A shorter pulse never reaches a gate. From an idle leg whose dead time has elapsed, a new command drives its gate FILT_LEN+1 edges after it was applied.
- R9: cfg_dead and cfg_refresh are captured only while rst is high. Changing them afterwards has no effect until the next reset.
- R10: After dis_n returns high, no gate turns on until D cycles, with a minimum of one, have passed with dis_n high. The count starts at the first edge that samples dis_n high.
- R11: While rst is high, and after it until a command is accepted, all four gates are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; captures configuration |
| cfg_dead | input | CNT_W | Dead time in clock cycles |
| cfg_refresh | input | CNT_W | Refresh pulse width in clock cycles |
| cmd_ah | input | 1 | Leg A high-side command |
| cmd_al | input | 1 | Leg A low-side command |
| cmd_bh | input | 1 | Leg B high-side command |
| cmd_bl | input | 1 | Leg B low-side command |
| dis_n | input | 1 | Global disable, active low |
| uv_main | input | 1 | Main supply undervoltage flag |
| uv_hs | input | 1 | High-side supply undervoltage flag |
| gate_ah | output | 1 | Leg A high-side gate enable |
| gate_al | output | 1 | Leg A low-side gate enable |
| gate_bh | output | 1 | Leg B high-side gate enable |
| gate_bl | output | 1 | Leg B low-side gate enable |

## Verification
The bench builds the block with CNT_W = 8 and FILT_LEN = 3. With these values a full filter, dead-time and switch-over sequence takes only tens of cycles, and a filter window of three lets a two-cycle glitch be shown to vanish. Through the configuration inputs it applies dead times of 0, 5 and 12, so the one-cycle floor and longer gaps are both measured. It uses refresh widths of 4 and 0, and it also rewrites the configuration after reset to show that the captured values hold.

// File: rtl/hbridge_gate_ctl.sv
module hbridge_gate_ctl #(
  parameter int CNT_W    = 10,
  parameter int FILT_LEN = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_dead,
  input  logic [CNT_W-1:0] cfg_refresh,
  input  logic             cmd_ah,
  input  logic             cmd_al,
  input  logic             cmd_bh,
  input  logic             cmd_bl,
  input  logic             dis_n,
  input  logic             uv_main,
  input  logic             uv_hs,
  output logic             gate_ah,
  output logic             gate_al,
  output logic             gate_bh,
  output logic             gate_bl
);
  localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [FW-1:0] FLAST = FW'(FILT_LEN - 1);

  logic [3:0]       raw, filt, g;
  logic [FW-1:0]    fcnt [4];
  logic [CNT_W-1:0] dead_r, ref_r, ref_cnt;
  logic             dis_q, refresh_on, off_all;

  assign raw = {cmd_ah, cmd_al, cmd_bh, cmd_bl};
  assign {gate_ah, gate_al, gate_bh, gate_bl} = g;

  generate
    for (genvar i = 0; i < 4; i++) begin : g_filt
      always_ff @(posedge clk) begin
        if (rst) begin
          filt[i] <= 1'b0;
          fcnt[i] <= '0;
        end else if (raw[i] == filt[i]) begin
          fcnt[i] <= '0;
        end else if (fcnt[i] == FLAST) begin
          filt[i] <= raw[i];
          fcnt[i] <= '0;
        end else begin
          fcnt[i] <= fcnt[i] + FW'(1);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q   <= 1'b1;
      dead_r  <= cfg_dead;
      ref_r   <= cfg_refresh;
      ref_cnt <= '0;
    end else begin
      dis_q <= dis_n;
      if (dis_q && !dis_n)
        ref_cnt <= ref_r;
      else if (!dis_n && ref_cnt != '0)
        ref_cnt <= ref_cnt - CNT_W'(1);
      else if (dis_n)
        ref_cnt <= '0;
    end
  end

  assign refresh_on = !dis_n && (ref_cnt != '0) && !uv_main;
  assign off_all    = uv_main || !dis_n;

  generate
    for (genvar l = 0; l < 2; l++) begin : g_leg
      localparam int HI = 2 * l + 1;
      localparam int LO = 2 * l;
      logic [CNT_W-1:0] dcnt;
      logic             any_on, ok, lo_req, hi_req;

      assign any_on = g[HI] || g[LO];
      assign ok     = !any_on && dis_q &&
                      (({1'b0, dcnt} + (CNT_W+1)'(1)) >= {1'b0, dead_r});
      assign lo_req = filt[LO] && !off_all;
      assign hi_req = filt[HI] && !filt[LO] && !off_all && !uv_hs;

      always_ff @(posedge clk) begin
        if (rst) begin
          dcnt  <= '0;
          g[HI] <= 1'b0;
          g[LO] <= 1'b0;
        end else begin
          if (any_on || !dis_n || !dis_q)
            dcnt <= '0;
          else if (dcnt != '1)
            dcnt <= dcnt + CNT_W'(1);
          g[HI] <= hi_req && (g[HI] || ok);
          g[LO] <= refresh_on || (lo_req && ((g[LO] && dis_q) || ok));
        end
      end
    end
  endgenerate
endmodule

module hbridge_gate_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             dis_n,
  input logic             uv_main,
  input logic             uv_hs,
  input logic             gate_ah,
  input logic             gate_al,
  input logic             gate_bh,
  input logic             gate_bl,
  input logic [CNT_W-1:0] dead_r
);
  logic [CNT_W-1:0] offa, offb;

  always_ff @(posedge clk) begin
    if (rst || gate_ah || gate_al || !dis_n) offa <= '0;
    else if (offa != '1) offa <= offa + CNT_W'(1);
    if (rst || gate_bh || gate_bl || !dis_n) offb <= '0;
    else if (offb != '1) offb <= offb + CNT_W'(1);
  end

  a_r1_leg_a_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_ah && gate_al));
  a_r1_leg_b_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_bh && gate_bl));
  a_r3_dead_leg_a: assert property (@(posedge clk) disable iff (rst)
    (((gate_ah && !$past(gate_ah)) || (gate_al && !$past(gate_al))) && $past(dis_n))
    |-> offa >= dead_r);
  a_r3_dead_leg_b: assert property (@(posedge clk) disable iff (rst)
    (((gate_bh && !$past(gate_bh)) || (gate_bl && !$past(gate_bl))) && $past(dis_n))
    |-> offb >= dead_r);
  a_r4_disable_high_off: assert property (@(posedge clk) disable iff (rst)
    !dis_n |=> (!gate_ah && !gate_bh));
  a_r5_entry_all_off: assert property (@(posedge clk) disable iff (rst)
    $fell(dis_n) |=> (!gate_al && !gate_bl));
  a_r5_lows_paired: assert property (@(posedge clk) disable iff (rst)
    (!dis_n && !$past(dis_n)) |-> (gate_al == gate_bl));
  a_r6_uv_main_off: assert property (@(posedge clk) disable iff (rst)
    uv_main |=> !(gate_ah || gate_al || gate_bh || gate_bl));
  a_r7_uv_hs_high_off: assert property (@(posedge clk) disable iff (rst)
    uv_hs |=> (!gate_ah && !gate_bh));
endmodule

bind hbridge_gate_ctl hbridge_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .dis_n(dis_n), .uv_main(uv_main), .uv_hs(uv_hs),
  .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl),
  .dead_r(dead_r)
);

// File: tb/tb_hbridge_gate_ctl.sv
`timescale 1ns/1ps
module tb_hbridge_gate_ctl;
  localparam int CW = 8;
  localparam int FL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg_dead = 8'd5, cfg_refresh = 8'd4;
  logic cmd_ah = 0, cmd_al = 0, cmd_bh = 0, cmd_bl = 0;
  logic dis_n = 1, uv_main = 0, uv_hs = 0;
  logic gate_ah, gate_al, gate_bh, gate_bl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbridge_gate_ctl #(.CNT_W(CW), .FILT_LEN(FL)) dut (
    .clk(clk), .rst(rst), .cfg_dead(cfg_dead), .cfg_refresh(cfg_refresh),
    .cmd_ah(cmd_ah), .cmd_al(cmd_al), .cmd_bh(cmd_bh), .cmd_bl(cmd_bl),
    .dis_n(dis_n), .uv_main(uv_main), .uv_hs(uv_hs),
    .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
  );

  function automatic logic [3:0] gv();
    return {gate_ah, gate_al, gate_bh, gate_bl};
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_g(input string req, input logic [3:0] exp);
    checks++;
    if (gv() !== exp) begin
      errors++;
      $display("FAIL %s: gates actual %b expected %b", req, gv(), exp);
    end
  endtask

  task automatic chk_n(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cmd(input logic ah, al, bh, bl);
    cmd_ah = ah; cmd_al = al; cmd_bh = bh; cmd_bl = bl;
  endtask

  task automatic do_reset(input int d, input int w);
    tick();
    rst = 1; cfg_dead = CW'(d); cfg_refresh = CW'(w);
    set_cmd(0, 0, 0, 0); dis_n = 1; uv_main = 0; uv_hs = 0;
    tick(3);
    chk_g("R11 during reset", 4'b0000);
    rst = 0;
    tick(20);
    chk_g("R11 after reset", 4'b0000);
  endtask

  // leg A switch-over with cmd_ah held high; returns off gap and off sample
  task automatic leg_a_switch(input logic to_low, output int gap, output int off_at);
    gap = 0; off_at = 0;
    cmd_al = to_low;
    for (int i = 1; i <= 80; i++) begin
      tick();
      if (to_low ? gate_al : gate_ah) break;
      if (!gate_ah && !gate_al) begin
        gap++;
        if (off_at == 0) off_at = i;
      end
    end
  endtask

  task automatic t_filter();
    do_reset(5, 4);
    cmd_al = 1; tick(2); cmd_al = 0;
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin tick(); if (gv() != 0) seen++; end
      chk_n("R8 short pulse ignored", seen, 0);
    end
    cmd_al = 1;
    tick(FL);
    chk_g("R8 not yet accepted", 4'b0000);
    tick();
    chk_g("R8 accepted latency", 4'b0100);
  endtask

  task automatic t_priority();
    do_reset(2, 4);
    set_cmd(1, 1, 1, 1); tick(30);
    chk_g("R2 low wins on both legs", 4'b0101);
    set_cmd(1, 0, 1, 0); tick(30);
    chk_g("R1 both highs", 4'b1010);
    set_cmd(0, 0, 0, 1); tick(30);
    chk_g("R1 single low", 4'b0001);
    set_cmd(1, 0, 0, 1); tick(30);
    chk_g("R1 cross high and low", 4'b1001);
  endtask

  task automatic t_dead(input int d);
    int gap, off_at, expd;
    expd = (d < 1) ? 1 : d;
    do_reset(d, 4);
    set_cmd(1, 0, 0, 0); tick(30);
    chk_g("R3 high on", 4'b1000);
    leg_a_switch(1'b1, gap, off_at);
    chk_n("R3 turn-off edge", off_at, FL + 1);
    chk_n("R3 gap high to low", gap, expd);
    chk_g("R3 low on", 4'b0100);
    tick(10);
    leg_a_switch(1'b0, gap, off_at);
    chk_n("R3 gap low to high", gap, expd);
  endtask

  task automatic t_config();
    int gap, off_at;
    do_reset(5, 4);
    cfg_dead = 8'd1;
    set_cmd(1, 0, 0, 0); tick(30);
    leg_a_switch(1'b1, gap, off_at);
    chk_n("R9 dead time held", gap, 5);
  endtask

  task automatic t_disable();
    int pulse, stray, off;
    do_reset(5, 4);
    cfg_refresh = 8'd9;
    set_cmd(1, 0, 1, 0); tick(30);
    chk_g("R1 both highs before disable", 4'b1010);
    dis_n = 0; tick();
    chk_g("R4 R5 entry all off", 4'b0000);
    pulse = 0; stray = 0;
    for (int i = 0; i < 14; i++) begin
      tick();
      if (gv() == 4'b0101) pulse++;
      else if (gv() != 4'b0000) stray++;
    end
    chk_n("R5 refresh width", pulse, 4);
    chk_n("R4 no high during disable", stray, 0);
    set_cmd(0, 1, 0, 0); tick(10);
    chk_g("R5 lows held off", 4'b0000);
    dis_n = 1; off = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (gate_al) break;
      off++;
    end
    chk_n("R10 exit dead time", off, 5);
    do_reset(3, 0);
    dis_n = 0; stray = 0;
    for (int i = 0; i < 10; i++) begin tick(); if (gv() != 0) stray++; end
    chk_n("R5 zero width no pulse", stray, 0);
  endtask

  task automatic t_uv();
    do_reset(2, 4);
    set_cmd(0, 1, 1, 0); tick(30);
    chk_g("R1 low and high on separate legs", 4'b0110);
    uv_main = 1; tick();
    chk_g("R6 uv_main next cycle", 4'b0000);
    set_cmd(1, 0, 1, 1); tick(10);
    chk_g("R6 uv_main holds", 4'b0000);
    uv_main = 0;
    do_reset(2, 4);
    set_cmd(1, 0, 0, 1); tick(30);
    chk_g("R7 start", 4'b1001);
    uv_hs = 1; tick();
    chk_g("R7 high off next cycle", 4'b0001);
    set_cmd(1, 1, 0, 0); tick(20);
    chk_g("R7 lows follow", 4'b0100);
    uv_hs = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    t_filter();
    t_priority();
    t_dead(5);
    t_dead(12);
    t_dead(0);
    t_config();
    t_disable();
    t_uv();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule